// File: doc/BRIEF.md
# Bayer Mosaic Half-Resolution RGB Converter

This block turns the raw sample stream of a colour image sensor, laid out as a Bayer mosaic, into packed RGB pixels at half the sensor resolution in each axis. The sensor supplies one sample per pixel clock, qualified by a frame-valid and a line-valid signal. A one-line store holds the previous row, so each sample arrives together with the sample directly above it. Every 2x2 mosaic cell (green and red on the even row, blue and green on the odd row) collapses into one output pixel with 10 bits per colour, a one-cycle valid strobe and the pixel's X/Y position in the reduced frame.

With the default geometry a 1280 by 1024 sensor frame becomes a 640 by 512 RGB frame. The block is meant to sit between a sensor capture front end and a frame writer, which uses the strobe and coordinates to place the pixel.

Top module: `bayer_half_rgb`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, out_valid is low; out_rgb, out_x and out_y are zero until the first cell completes.
- R2: A sample is taken only on a clock edge where frame_valid and line_valid are both high; raw_in on any other edge has no effect on any output.
- R3: Counting rows and columns of taken samples from zero, out_valid pulses for exactly one cycle on the clock edge after the edge that takes the sample at an odd row and odd column; a full frame gives SENSOR_W/2 * SENSOR_H/2 pulses and no two pulses are adjacent.
- R4: Red is the cell's sample at even row, odd column, placed in out_rgb bits 9:0.
- R5: Blue is the cell's sample at odd row, even column, placed in out_rgb bits 29:20.
- R6: Green is floor((G_even + G_odd)/2) of the cell's samples at even row, even column and odd row, odd column, placed in out_rgb bits 19:10 (1023 and 1022 give 1022; 0 and 1 give 0).
- R7: With a strobe, out_x is the column of the completing sample divided by two and out_y its row divided by two, always below SENSOR_W/2 and SENSOR_H/2.
- R8: The column count restarts at zero at the start of each line, the row count advances when line_valid falls, and both restart at zero when frame_valid rises, also after a frame cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | High for the duration of a sensor frame |
| line_valid | input | 1 | High while a row's samples are presented |
| raw_in | input | DATA_W | Raw mosaic sample |
| out_valid | output | 1 | One-cycle strobe for a completed cell |
| out_rgb | output | 3*DATA_W | Packed pixel: blue high, green middle, red low |
| out_x | output | $clog2(SENSOR_W)-1 | Output column |
| out_y | output | $clog2(SENSOR_H)-1 | Output row |

## Verification
The bench builds the block with an 8 by 6 sensor, so the line store is eight entries deep and an output frame is 4 by 3 pixels. At that size every cell position, including the last column and the last row, and full frames with a cut-short frame before them fall within a few hundred cycles. The small width also means a junk sample written into the store between lines would land in a slot that the next odd row reads, so a gating fault shows up as a wrong colour.

// File: rtl/bayer_half_pkg.sv
package bayer_half_pkg;
   // colour lanes of the packed pixel, lowest lane in the lowest bits
   typedef enum int {
      LANE_RED   = 0,
      LANE_GREEN = 1,
      LANE_BLUE  = 2
   } lane_e;
   localparam int LANES = 3;
endpackage

// File: rtl/bayer_pos_track.sv
module bayer_pos_track #(
   parameter int COL_W = 11,
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_valid,
   input  logic             line_valid,
   output logic             take,
   output logic [COL_W-1:0] col,
   output logic [ROW_W-1:0] row
);
   logic line_q;

   assign take = frame_valid & line_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col    <= '0;
         row    <= '0;
         line_q <= 1'b0;
      end else begin
         line_q <= line_valid;
         if (!take) col <= '0;
         else       col <= col + 1'b1;
         if (!frame_valid)              row <= '0;
         else if (line_q && !line_valid) row <= row + 1'b1;
      end
   end
endmodule

// File: rtl/bayer_line_store.sv
module bayer_line_store #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 1280,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic              take,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] above
);
   logic [DATA_W-1:0] mem [DEPTH];

   // read returns the previous row's sample at this column before the write
   assign above = mem[idx];

   always_ff @(posedge clk) begin
      if (take) mem[idx] <= din;
   end
endmodule

// File: rtl/bayer_cell_join.sv
module bayer_cell_join
   import bayer_half_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int COL_W  = 11,
   parameter int ROW_W  = 10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [COL_W-1:0]        col,
   input  logic [ROW_W-1:0]        row,
   input  logic [DATA_W-1:0]       din,
   input  logic [DATA_W-1:0]       above,
   output logic                    out_valid,
   output logic [LANES*DATA_W-1:0] out_rgb,
   output logic [COL_W-2:0]        out_x,
   output logic [ROW_W-2:0]        out_y
);
   logic [DATA_W-1:0] left_q;
   logic [DATA_W-1:0] above_left_q;
   logic [DATA_W:0]   green_sum;
   logic [DATA_W-1:0] lane [LANES];
   logic              cell_done;

   assign cell_done = take & row[0] & col[0];
   assign green_sum = {1'b0, above_left_q} + {1'b0, din};

   always_comb begin
      lane[int'(LANE_RED)]   = above;
      lane[int'(LANE_GREEN)] = green_sum[DATA_W:1];
      lane[int'(LANE_BLUE)]  = left_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q       <= '0;
         above_left_q <= '0;
         out_valid    <= 1'b0;
         out_x        <= '0;
         out_y        <= '0;
      end else begin
         out_valid <= cell_done;
         if (take) begin
            left_q       <= din;
            above_left_q <= above;
         end
         if (cell_done) begin
            out_x <= col[COL_W-1:1];
            out_y <= row[ROW_W-1:1];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)         out_rgb[g*DATA_W +: DATA_W] <= '0;
         else if (cell_done) out_rgb[g*DATA_W +: DATA_W] <= lane[g];
      end
   end
endmodule

// File: rtl/bayer_half_rgb.sv
module bayer_half_rgb #(
   parameter  int DATA_W   = 10,
   parameter  int SENSOR_W = 1280,
   parameter  int SENSOR_H = 1024,
   localparam int COL_W    = $clog2(SENSOR_W),
   localparam int ROW_W    = $clog2(SENSOR_H),
   localparam int X_W      = COL_W - 1,
   localparam int Y_W      = ROW_W - 1,
   localparam int PIX_W    = 3 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic              line_valid,
   input  logic [DATA_W-1:0] raw_in,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_rgb,
   output logic [X_W-1:0]    out_x,
   output logic [Y_W-1:0]    out_y
);
   if (SENSOR_W < 4 || (SENSOR_W % 2) != 0) begin : g_bad_width
      $error("SENSOR_W must be even and at least 4");
   end
   if (SENSOR_H < 4 || (SENSOR_H % 2) != 0) begin : g_bad_height
      $error("SENSOR_H must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end

   logic              take;
   logic [COL_W-1:0]  col;
   logic [ROW_W-1:0]  row;
   logic [DATA_W-1:0] above;

   bayer_pos_track #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_valid(frame_valid),
      .line_valid (line_valid),
      .take       (take),
      .col        (col),
      .row        (row)
   );

   bayer_line_store #(.DATA_W(DATA_W), .DEPTH(SENSOR_W), .AW(COL_W)) u_store (
      .clk  (clk),
      .take (take),
      .idx  (col),
      .din  (raw_in),
      .above(above)
   );

   bayer_cell_join #(.DATA_W(DATA_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_join (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .col      (col),
      .row      (row),
      .din      (raw_in),
      .above    (above),
      .out_valid(out_valid),
      .out_rgb  (out_rgb),
      .out_x    (out_x),
      .out_y    (out_y)
   );
endmodule

// File: rtl/bayer_half_rgb_chk.sv
module bayer_half_rgb_chk #(
   parameter int SENSOR_W = 1280,
   parameter int SENSOR_H = 1024,
   parameter int X_W      = 10,
   parameter int Y_W      = 9
) (
   input logic           clk,
   input logic           rst_n,
   input logic           frame_valid,
   input logic           line_valid,
   input logic           out_valid,
   input logic [X_W-1:0] out_x,
   input logic [Y_W-1:0] out_y
);
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && line_valid) |=> !out_valid);

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   assert_x_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_x) < SENSOR_W / 2));

   assert_y_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_y) < SENSOR_H / 2));
endmodule

bind bayer_half_rgb bayer_half_rgb_chk #(
   .SENSOR_W(SENSOR_W), .SENSOR_H(SENSOR_H), .X_W(X_W), .Y_W(Y_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_valid(frame_valid),
   .line_valid (line_valid),
   .out_valid  (out_valid),
   .out_x      (out_x),
   .out_y      (out_y)
);

// File: tb/bayer_half_rgb_tb.sv
module bayer_half_rgb_tb;
   localparam int DW = 10;
   localparam int W  = 8;
   localparam int H  = 6;
   localparam int XW = $clog2(W) - 1;
   localparam int YW = $clog2(H) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_valid = 1'b0;
   logic          line_valid = 1'b0;
   logic [DW-1:0] raw_in = '0;
   logic          out_valid;
   logic [3*DW-1:0] out_rgb;
   logic [XW-1:0] out_x;
   logic [YW-1:0] out_y;

   always #5 clk = ~clk;

   bayer_half_rgb #(.DATA_W(DW), .SENSOR_W(W), .SENSOR_H(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .line_valid(line_valid),
      .raw_in(raw_in), .out_valid(out_valid), .out_rgb(out_rgb),
      .out_x(out_x), .out_y(out_y)
   );

   int n_chk = 0;
   int n_err = 0;
   int strobes = 0;
   logic done = 1'b0;
   string scen = "";
   logic [DW-1:0] img [H][W];
   logic          pend_valid = 1'b0;
   logic [DW-1:0] pend_r, pend_g, pend_b;
   int            pend_x, pend_y;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
      end
   endtask

   task automatic check_pending();
      check(out_valid == pend_valid, "R3 strobe", int'(out_valid), int'(pend_valid));
      if (out_valid) strobes++;
      if (pend_valid && out_valid) begin
         check(out_rgb[9:0] == pend_r, "R4 red", int'(out_rgb[9:0]), int'(pend_r));
         check(out_rgb[19:10] == pend_g, "R6 green", int'(out_rgb[19:10]), int'(pend_g));
         check(out_rgb[29:20] == pend_b, "R5 blue", int'(out_rgb[29:20]), int'(pend_b));
         check(int'(out_x) == pend_x, "R7 x", int'(out_x), pend_x);
         check(int'(out_y) == pend_y, "R7 y", int'(out_y), pend_y);
      end
   endtask

   task automatic drive(input bit fv, input bit lv, input logic [DW-1:0] d,
                        input int r, input int c);
      int gs;
      @(negedge clk);
      check_pending();
      frame_valid = fv;
      line_valid  = lv;
      raw_in      = d;
      pend_valid  = fv && lv && (r % 2 == 1) && (c % 2 == 1);
      if (pend_valid) begin
         pend_r = img[r-1][c];
         pend_b = img[r][c-1];
         gs     = int'(img[r-1][c-1]) + int'(img[r][c]);
         pend_g = DW'(gs / 2);
         pend_x = c / 2;
         pend_y = r / 2;
      end
   endtask

   task automatic fill_img(input int seed);
      for (int r = 0; r < H; r++)
         for (int c = 0; c < W; c++)
            img[r][c] = DW'((r * 131 + c * 29 + seed * 67) % 1024);
   endtask

   // sends rows 0..nrows-1, gap cycles carry junk data with line_valid low
   task automatic send_rows(input int nrows, input int gap);
      for (int r = 0; r < nrows; r++) begin
         for (int c = 0; c < W; c++) drive(1'b1, 1'b1, img[r][c], r, c);
         for (int k = 0; k < gap; k++) drive(1'b1, 1'b0, DW'(1023 - 5 * r - k), 0, 0);
      end
   endtask

   task automatic frame_end();
      for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, '0, 0, 0);
   endtask

   task automatic t_reset_R1();
      scen = "R1 reset";
      rst_n = 1'b0;
      frame_valid = 1'b1; line_valid = 1'b1; raw_in = 10'h2AA;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      end
      frame_valid = 1'b0; line_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
      check(out_rgb == '0, "R1 rgb after reset", int'(out_rgb), 0);
      check(out_x == '0 && out_y == '0, "R1 xy after reset", int'(out_x) + int'(out_y), 0);
      pend_valid = 1'b0;
   endtask

   task automatic t_plain_frame_R3();
      scen = "R3 plain frame";
      fill_img(1);
      strobes = 0;
      send_rows(H, 1);
      frame_end();
      check(strobes == (W / 2) * (H / 2), "R3 strobe count", strobes, (W / 2) * (H / 2));
   endtask

   task automatic t_green_extremes_R6();
      scen = "R6 green extremes";
      fill_img(2);
      img[0][0] = 10'd1023; img[1][1] = 10'd1022;
      img[0][2] = 10'd1023; img[1][3] = 10'd1023;
      img[0][4] = 10'd0;    img[1][5] = 10'd1;
      img[0][6] = 10'd0;    img[1][7] = 10'd0;
      img[0][1] = 10'd1023; img[1][0] = 10'd0;
      send_rows(H, 1);
      frame_end();
   endtask

   task automatic t_gap_junk_R2();
      scen = "R2 junk while invalid";
      fill_img(3);
      // line_valid high but frame_valid low: ignored
      for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, DW'(777 + k), 0, 0);
      drive(1'b0, 1'b0, '0, 0, 0);
      strobes = 0;
      send_rows(H, 3);
      frame_end();
      check(strobes == (W / 2) * (H / 2), "R2 strobe count", strobes, (W / 2) * (H / 2));
   endtask

   task automatic t_abort_restart_R8();
      scen = "R8 cut frame then restart";
      fill_img(4);
      send_rows(3, 1);
      frame_end();
      fill_img(5);
      strobes = 0;
      send_rows(H, 2);
      frame_end();
      check(strobes == (W / 2) * (H / 2), "R8 strobe count", strobes, (W / 2) * (H / 2));
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired [%s]", scen);
         summary();
         $finish;
      end
   end

   initial begin
      t_reset_R1();
      t_plain_frame_R3();
      t_green_extremes_R6();
      t_gap_junk_R2();
      t_abort_restart_R8();
      drive(1'b0, 1'b0, '0, 0, 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule